// File: doc/BRIEF.md
# Keyed Register Lock Controller

This block holds one 32-bit control word and a small sticky field-lock register behind a plain register-bus port. After reset the whole bank is locked. Every write is dropped except a write to the key register. Writing the correct 32-bit key releases the lock. Once released, the lock stays released until the next reset. A wrong key written while the bank is still locked is treated as tampering. The bank then clears a set of security-related control bits as a penalty.

Separately, each bit of the field-lock register freezes one group of control-word bits. Once such a bit is set, later writes to the control word leave that group at its old value and update everything else. The bank also raises a warning output when the 3-bit encryption-enable field holds a partial pattern. Reads of every register are served combinationally from the current address, and neither lock ever blocks them.

Top module: `keylock_ctrl`

## Requirements
- R1: After synchronous reset the control word is 0x0C006000 (bits 27, 26, 14 and 13 set), the field-lock register is 0 and the global lock output is 1.
- R2: While the global lock is 1, writes to the control word (address 0) and to the field-lock register (address 1) change nothing.
- R3: Writing exactly 0x757BDF0D to the key register (address 2) drives the global lock to 0 on the next clock edge; it then stays 0 until reset, whatever is written afterwards.
- R4: Writing any other value to the key register while locked clears control bit 27 and control bits 11:9, leaves every other bit and the lock unchanged; the same write while unlocked has no effect.
- R5: The field-lock register is 5 bits (bits 4:0 at address 1); a write ORs the data into it, so a set bit can never be cleared except by reset.
- R6: Field-lock bit 4 freezes control bit 12, bit 3 freezes bits 11:9, bit 2 freezes bit 8, bit 1 freezes bit 7 and bit 0 freezes bits 6:0; a control-word write keeps frozen bits at their old values and takes the written data in all other bits.
- R7: Control bit 31 is not implemented: it always reads 0 and writes to it are ignored.
- R8: The warning output is 1 exactly when control bits 11:9 hold a value other than 000 or 111.
- R9: Read data is combinational from the address: address 0 gives the control word, address 1 gives the field-lock bits in bits 4:0, address 2 gives the global lock in bit 0, any other address gives 0; reads are never blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for the current address |
| ctrl_q | output | 32 | Current control word |
| locked | output | 1 | Global lock state |
| cfg_warn | output | 1 | Inconsistent encryption-enable field |

## Verification
The main write path is exercised in several situations. Control-word writes are tried while locked, with all-ones and all-zeros data after unlocking, and with field-lock masks built up one group at a time. The all-ones and all-zeros writes show whether a frozen group keeps its old value or takes the written data. A wrong key is sent once while locked and once after unlocking, which separates the penalty from a key compare that ignores the lock state. An attempt to clear field-lock bits shows they are sticky. A reset in the middle of the run shows that the lock and the control word return to their reset values. Field values 010 and 111 separate the warning decode from a plain non-zero test.

// File: rtl/keylock_pkg.sv
package keylock_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int LOCK_W = 5;

    localparam logic [DATA_W-1:0] CTRL_RESET  = 32'h0C00_6000;
    localparam int                BIT_UNIMPL  = 31;
    localparam int                BIT_PENALTY = 27;
    localparam int                AES_LO      = 9;
    localparam int                AES_W       = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL = 4'd0,
        SEL_FLD  = 4'd1,
        SEL_KEY  = 4'd2
    } reg_sel_e;

    typedef struct packed {
        logic ctrl;
        logic fld;
        logic key;
    } wr_strobe_t;

    // bits of the control word governed by one field-lock bit
    function automatic logic [DATA_W-1:0] group_of(input int idx);
        logic [DATA_W-1:0] m;
        m = '0;
        case (idx)
            4:       m[12] = 1'b1;
            3:       m[AES_LO +: AES_W] = '1;
            2:       m[8] = 1'b1;
            1:       m[7] = 1'b1;
            0:       m[6:0] = '1;
            default: m = '0;
        endcase
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] penalty_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        m[BIT_PENALTY] = 1'b1;
        m[AES_LO +: AES_W] = '1;
        return m;
    endfunction

    function automatic logic aes_partial(input logic [AES_W-1:0] f);
        return (f != '0) && (f != '1);
    endfunction

endpackage

// File: rtl/keylock_decode.sv
module keylock_decode
    import keylock_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output wr_strobe_t        stb
);
    always_comb begin
        stb.ctrl = we && (addr == SEL_CTRL);
        stb.fld  = we && (addr == SEL_FLD);
        stb.key  = we && (addr == SEL_KEY);
    end
endmodule

// File: rtl/keylock_gate.sv
module keylock_gate
    import keylock_pkg::*;
#(
    parameter logic [DATA_W-1:0] KEY = 32'h757B_DF0D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_we,
    input  logic [DATA_W-1:0] wdata,
    output logic              locked,
    output logic              bad_key
);
    logic key_match;

    assign key_match = (wdata == KEY);
    assign bad_key   = key_we && locked && !key_match;

    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b1;
        end else if (key_we && key_match) begin
            locked <= 1'b0;
        end
    end

    // R3: the right key releases the lock on the next edge
    p_key_release_r3: assert property (@(posedge clk) disable iff (rst)
        (key_we && wdata == KEY) |=> !locked);

    // R3: once released, the lock never comes back without reset
    p_stay_open_r3: assert property (@(posedge clk) disable iff (rst)
        !locked |=> !locked);

    // R4: a wrong key does not release the lock
    p_wrong_key_keeps_r4: assert property (@(posedge clk) disable iff (rst)
        bad_key |=> locked);
endmodule

// File: rtl/keylock_bank.sv
module keylock_bank
    import keylock_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_strobe_t        stb,
    input  logic              locked,
    input  logic              bad_key,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [LOCK_W-1:0] fld_q
);
    logic [DATA_W-1:0] grp [LOCK_W];
    logic [DATA_W-1:0] frozen;
    logic [DATA_W-1:0] ctrl_d;

    for (genvar g = 0; g < LOCK_W; g++) begin : g_grp
        assign grp[g] = fld_q[g] ? group_of(g) : '0;
    end

    always_comb begin
        frozen = '0;
        for (int i = 0; i < LOCK_W; i++) begin
            frozen = frozen | grp[i];
        end
    end

    always_comb begin
        ctrl_d = ctrl_q;
        if (stb.ctrl && !locked) begin
            ctrl_d = (wdata & ~frozen) | (ctrl_q & frozen);
        end
        if (bad_key) begin
            ctrl_d = ctrl_d & ~penalty_mask();
        end
        ctrl_d[BIT_UNIMPL] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
            fld_q  <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            if (stb.fld && !locked) begin
                fld_q <= fld_q | wdata[LOCK_W-1:0];
            end
        end
    end

    p_ctrl_blocked_r2: assert property (@(posedge clk) disable iff (rst)
        (locked && !bad_key) |=> $stable(ctrl_q));

    p_fld_blocked_r2: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(fld_q));

    p_penalty_r4: assert property (@(posedge clk) disable iff (rst)
        bad_key |=> (!ctrl_q[BIT_PENALTY] && ctrl_q[AES_LO +: AES_W] == '0));

    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((fld_q & $past(fld_q)) == $past(fld_q)));

    p_freeze12_r6: assert property (@(posedge clk) disable iff (rst)
        (fld_q[4] && !bad_key) |=> (ctrl_q[12] == $past(ctrl_q[12])));

    p_unimpl_r7: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q[BIT_UNIMPL]);
endmodule

// File: rtl/keylock_rdmux.sv
module keylock_rdmux
    import keylock_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] ctrl_q,
    input  logic [LOCK_W-1:0] fld_q,
    input  logic              locked,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        case (addr)
            SEL_CTRL: rdata = ctrl_q;
            SEL_FLD:  rdata = {{(DATA_W-LOCK_W){1'b0}}, fld_q};
            SEL_KEY:  rdata = {{(DATA_W-1){1'b0}}, locked};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/keylock_ctrl.sv
module keylock_ctrl
    import keylock_pkg::*;
#(
    parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h757B_DF0D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              locked,
    output logic              cfg_warn
);
    wr_strobe_t        stb;
    logic              bad_key;
    logic [LOCK_W-1:0] fld_q;

    keylock_decode u_dec (
        .addr (bus_addr),
        .we   (bus_we),
        .stb  (stb)
    );

    keylock_gate #(.KEY(UNLOCK_KEY)) u_gate (
        .clk     (clk),
        .rst     (rst),
        .key_we  (stb.key),
        .wdata   (bus_wdata),
        .locked  (locked),
        .bad_key (bad_key)
    );

    keylock_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .stb     (stb),
        .locked  (locked),
        .bad_key (bad_key),
        .wdata   (bus_wdata),
        .ctrl_q  (ctrl_q),
        .fld_q   (fld_q)
    );

    keylock_rdmux u_rd (
        .addr   (bus_addr),
        .ctrl_q (ctrl_q),
        .fld_q  (fld_q),
        .locked (locked),
        .rdata  (bus_rdata)
    );

    assign cfg_warn = aes_partial(ctrl_q[AES_LO +: AES_W]);

    // R8: a clean field (all zeros or all ones) never warns
    p_warn_clean_r8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[11:9] == 3'b000 || ctrl_q[11:9] == 3'b111) |-> !cfg_warn);
endmodule

// File: tb/sim_keylock_ctrl.sv
module sim_keylock_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] ctrl_q;
    logic        locked;
    logic        cfg_warn;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    keylock_ctrl u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .ctrl_q(ctrl_q),
        .locked(locked), .cfg_warn(cfg_warn)
    );

    typedef struct packed {
        logic [3:0]  a;
        logic [31:0] d;
        logic [31:0] c;
        logic        l;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{4'h0, 32'h1234_5678, 32'h0C00_6000, 1'b1},  // R2 ctrl write dropped
        '{4'h2, 32'hDEAD_BEEF, 32'h0400_6000, 1'b1},  // R4 penalty
        '{4'h1, 32'h0000_001F, 32'h0400_6000, 1'b1},  // R2 fld write dropped
        '{4'h2, 32'h757B_DF0D, 32'h0400_6000, 1'b0},  // R3 unlock
        '{4'h0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 1'b0},  // R7 bit31 ignored
        '{4'h2, 32'h0000_0000, 32'h7FFF_FFFF, 1'b0},  // R4 no effect unlocked
        '{4'h1, 32'h0000_0010, 32'h7FFF_FFFF, 1'b0},  // R5 set bit4
        '{4'h0, 32'h0000_0000, 32'h0000_1000, 1'b0},  // R6 bit12 held
        '{4'h1, 32'h0000_0008, 32'h0000_1000, 1'b0},  // R5 set bit3
        '{4'h0, 32'h0000_0E00, 32'h0000_1000, 1'b0},  // R6 11:9 held
        '{4'h1, 32'h0000_0000, 32'h0000_1000, 1'b0},  // R5 clear attempt
        '{4'h0, 32'hFFFF_FFFF, 32'h7FFF_F1FF, 1'b0},  // R6 mixed
        '{4'h1, 32'h0000_0007, 32'h7FFF_F1FF, 1'b0},  // R5 set 2..0
        '{4'h0, 32'h0000_0000, 32'h0000_11FF, 1'b0}   // R6 all groups held
    };

    function automatic string tag_of(input int i);
        case (i)
            0, 2:          return "R2";
            1, 5:          return "R4";
            3:             return "R3";
            4:             return "R7";
            6, 8, 10, 12:  return "R5";
            default:       return "R6";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        #(5 * 20000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1", ctrl_q, 32'h0C00_6000);
        chk("R1", {31'b0, locked}, 32'd1);
        rd("R1", 4'h1, 32'h0);
        rd("R9", 4'h2, 32'h1);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i].a, VEC[i].d);
            chk(tag_of(i), ctrl_q, VEC[i].c);
            chk(tag_of(i), {31'b0, locked}, {31'b0, VEC[i].l});
        end

        // R5 sticky bits all set, R9 readback never blocked
        rd("R5", 4'h1, 32'h1F);
        rd("R9", 4'h0, 32'h0000_11FF);
        rd("R9", 4'h2, 32'h0);
        rd("R9", 4'h5, 32'h0);
        chk("R8", {31'b0, cfg_warn}, 32'd0);

        // R1 reset mid-run restores lock and clears field locks
        do_reset();
        chk("R1", ctrl_q, 32'h0C00_6000);
        chk("R1", {31'b0, locked}, 32'd1);
        rd("R1", 4'h1, 32'h0);

        // R8 warning decode
        wr(4'h2, 32'h757B_DF0D);
        wr(4'h0, 32'h0000_0400);
        chk("R8", {31'b0, cfg_warn}, 32'd1);
        wr(4'h0, 32'h0000_0E00);
        chk("R8", {31'b0, cfg_warn}, 32'd0);
        wr(4'h0, 32'h0000_0C00);
        chk("R8", {31'b0, cfg_warn}, 32'd1);
        // R3 relock impossible: a wrong key after unlock leaves lock open and data intact
        wr(4'h2, 32'h1111_1111);
        chk("R3", {31'b0, locked}, 32'd0);
        chk("R4", ctrl_q, 32'h0000_0C00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule